// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Supply-Fail Lockout

This block is a two-wire serial slave that gives a host byte access to a 160-location register and RAM space. It responds to one fixed 7-bit device address. In a write transfer, the first data byte loads an internal address pointer. Each data byte after that is stored at the pointer, and the pointer then moves up by one. In a read transfer, the block returns bytes starting at the pointer, most significant bit first, and the pointer moves up after each byte. The pointer runs from 00h to 9Fh and then wraps back to 00h.

SCL and SDA are sampled by the system clock through synchroniser stages and then edge-detected. START and STOP are recognised as SDA edges that occur while SCL is high. The block drives SDA only through an open-drain output enable. A supply-fail input comes from an external comparator. It cancels any transfer in progress, releases SDA, sets the pointer to 00h and makes the block ignore the bus. When supply returns, stores to the byte array stay blocked for a recovery window of a set number of system clocks.

Top module: `i2cr_slave`

## Requirements
- R1: The slave acknowledges a first byte equal to 8'hD0 (write) or 8'hD1 (read), that is, 7-bit address 7'h68 followed by the direction bit (1 = read). It leaves SDA released for any other address and then ignores the bus until the next START.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A STOP returns the slave to idle, so bytes clocked afterwards without a START get no acknowledge. A repeated START begins a new address phase.
- R3: In a write transfer, the first data byte loads the pointer. An index of A0h or above loads 00h. Every later byte is stored at the pointer, and the pointer then increments. Every byte of the transfer is acknowledged.
- R4: In a read transfer, the slave sends the byte at the pointer MSB first and increments the pointer after each byte. It continues with the next byte while the master acknowledges.
- R5: After the master answers a read byte with NACK, the slave keeps SDA released until a STOP or a START.
- R6: The pointer wraps from 9Fh to 00h, both when writing and when reading.
- R7: Away from a START, a STOP or a supply fail, SDA output changes occur only while SCL is low, so SDA never changes while SCL is high.
- R8: Asserting the supply-fail input releases SDA within a few clocks, abandons the transfer and sets the pointer to 00h.
- R9: While the supply-fail input is asserted, the bus is ignored. An addressed transfer gets no acknowledge and stores nothing.
- R10: For RECOVER_CYCLES clocks after the supply-fail input deasserts, write data bytes are still acknowledged and still advance the pointer, but they leave the array unchanged. After that window, writes store normally.
- R11: After reset, SDA is released and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open drain) |
| pwr_fail_i | input | 1 | Supply-fail flag from external comparator, asynchronous |

## Verification
The internal state is only visible at SDA, so each fault has to show up on the bus. A wrong state or bit count shows up within one byte time, as a missing or misplaced acknowledge or as shifted read data. A wrong pointer shows up only on a later read, as a byte taken from the wrong location, which is why every write is read back through a repeated START. A lockout window that is too short or too long changes the value read back after a supply dip. An abort that is missing leaves SDA pulled low during the fail, and a missing pointer clear makes the first read after recovery return the wrong location.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WR,
    ST_ACK_WR,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } proto_state_e;
endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // control conditions need SCL high on both samples
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2cr_supply_guard.sv
module i2cr_supply_guard #(
  parameter int STAGES         = 2,
  parameter int RECOVER_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_fail_i,
  output logic fail_o,
  output logic wr_ok_o
);
  localparam int CNT_W = $clog2(RECOVER_CYCLES + 1);

  logic [STAGES-1:0] pf_q;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q <= '0;
      cnt  <= '0;
    end else begin
      pf_q <= {pf_q[STAGES-2:0], pwr_fail_i};
      if (pf_q[STAGES-1])  cnt <= CNT_W'(RECOVER_CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  assign fail_o  = pf_q[STAGES-1];
  assign wr_ok_o = !fail_o && (cnt == '0);

  a_r10_locked_after_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fail_o) |=> !wr_ok_o);
endmodule

// File: rtl/i2cr_byte_ram.sv
module i2cr_byte_ram #(
  parameter int DEPTH = 160,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2cr_proto.sv
module i2cr_proto
  import i2cr_pkg::*;
#(
  parameter int         DEPTH    = 160,
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         AW       = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          fail_i,
  input  logic          wr_ok_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] ptr_o,
  output logic          mem_we_o,
  output logic [7:0]    mem_wdata_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  proto_state_e state;
  logic [2:0]    bit_cnt;
  logic          full;
  logic [7:0]    rx_sh, tx_sh;
  logic          rd_mode, first, mack;
  logic [AW-1:0] ptr, ptr_nxt;

  assign ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      full     <= 1'b0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rd_mode  <= 1'b0;
      first    <= 1'b0;
      mack     <= 1'b0;
      ptr      <= '0;
      sda_oe_o <= 1'b0;
    end else if (fail_i) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      full     <= 1'b0;
      ptr      <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_i) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else if (start_i) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      full     <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      // receive path shared by address and write bytes
      if (scl_rise_i && (state == ST_ADDR || state == ST_WR)) begin
        rx_sh   <= {rx_sh[6:0], sda_i};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) full <= 1'b1;
      end
      if (scl_rise_i && state == ST_RD_ACK) mack <= ~sda_i;

      if (scl_fall_i) begin
        unique case (state)
          ST_ADDR: if (full) begin
            full <= 1'b0;
            if (rx_sh[7:1] == DEV_ADDR) begin
              rd_mode  <= rx_sh[0];
              first    <= 1'b1;
              sda_oe_o <= 1'b1;
              state    <= ST_ACK_ADDR;
            end else begin
              state <= ST_WAIT;
            end
          end
          ST_ACK_ADDR: begin
            bit_cnt <= '0;
            if (rd_mode) begin
              tx_sh    <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
              state    <= ST_RD;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= ST_WR;
            end
          end
          ST_WR: if (full) begin
            full <= 1'b0;
            if (first) begin
              first <= 1'b0;
              ptr   <= (int'(rx_sh) < DEPTH) ? AW'(rx_sh) : '0;
            end else begin
              ptr <= ptr_nxt;
            end
            sda_oe_o <= 1'b1;
            state    <= ST_ACK_WR;
          end
          ST_ACK_WR: begin
            sda_oe_o <= 1'b0;
            state    <= ST_WR;
          end
          ST_RD: begin
            if (bit_cnt == 3'd7) begin
              bit_cnt  <= '0;
              sda_oe_o <= 1'b0;
              ptr      <= ptr_nxt;
              state    <= ST_RD_ACK;
            end else begin
              bit_cnt  <= bit_cnt + 1'b1;
              tx_sh    <= {tx_sh[6:0], 1'b0};
              sda_oe_o <= ~tx_sh[6];
            end
          end
          ST_RD_ACK: begin
            if (mack) begin
              tx_sh    <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
              state    <= ST_RD;
            end else begin
              state <= ST_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o       = ptr;
  assign mem_wdata_o = rx_sh;
  assign mem_we_o    = !fail_i && !stop_i && !start_i && scl_fall_i && full &&
                       (state == ST_WR) && !first && wr_ok_i;

  a_r8_release_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> (!sda_oe_o && ptr_o == '0));
  a_r6_ptr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST);
  a_r6_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RD && scl_fall_i && bit_cnt == 3'd7 && ptr == LAST &&
     !fail_i && !stop_i && !start_i) |=> ptr == '0);
  a_r7_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(fail_i) && !$past(start_i) && !$past(stop_i))
      |-> !$past(scl_i));
  a_r5_quiet_after_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT) |-> !sda_oe_o);
endmodule

// File: rtl/i2cr_slave.sv
module i2cr_slave #(
  parameter int         DEPTH          = 160,
  parameter logic [6:0] DEV_ADDR       = 7'h68,
  parameter int         RECOVER_CYCLES = 1000,
  parameter int         SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic pwr_fail_i
);
  localparam int AW = $clog2(DEPTH);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic fail_s, wr_ok, mem_we;
  logic [AW-1:0] ptr;
  logic [7:0] rd_data, wr_data;

  i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2cr_supply_guard #(.STAGES(SYNC_STAGES), .RECOVER_CYCLES(RECOVER_CYCLES)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_fail_i(pwr_fail_i),
    .fail_o(fail_s), .wr_ok_o(wr_ok)
  );

  i2cr_proto #(.DEPTH(DEPTH), .DEV_ADDR(DEV_ADDR), .AW(AW)) u_proto (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
    .fail_i(fail_s), .wr_ok_i(wr_ok), .rd_data_i(rd_data),
    .sda_oe_o(sda_oe_o), .ptr_o(ptr), .mem_we_o(mem_we), .mem_wdata_o(wr_data)
  );

  i2cr_byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk_i(clk_i), .we_i(mem_we), .waddr_i(ptr), .wdata_i(wr_data),
    .raddr_i(ptr), .rdata_o(rd_data)
  );

  a_r10_no_store_when_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> wr_ok);
  a_r9_quiet_during_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_s && $past(fail_s)) |-> !sda_oe_o);
endmodule

// File: tb/tb_i2cr_slave.sv
module tb_i2cr_slave;
  localparam int HP      = 20;
  localparam int RECOVER = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, pf = 1'b0;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  i2cr_slave #(.RECOVER_CYCLES(RECOVER)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pwr_fail_i(pf)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HP/2);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b0; tick(HP/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HP/2);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b1; tick(HP);
  endtask

  task automatic write_bit(logic b);
    m_sda = b; tick(HP/2);
    m_scl = 1'b1; tick(HP);
    m_scl = 1'b0; tick(HP/2);
  endtask

  task automatic read_bit(output logic b, output logic steady);
    logic e;
    m_sda = 1'b1; tick(HP/2);
    m_scl = 1'b1; tick(2);
    e = sda_line; tick(HP-4);
    b = sda_line; steady = (e === b); tick(2);
    m_scl = 1'b0; tick(HP/2);
  endtask

  task automatic write_byte(logic [7:0] d, output logic ack);
    logic a, s;
    for (int i = 7; i >= 0; i--) write_bit(d[i]);
    read_bit(a, s);
    ack = !a;
  endtask

  task automatic read_byte(logic give_ack, output logic [7:0] d, output logic steady);
    logic b, s;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      read_bit(b, s);
      d[i] = b;
      steady &= s;
    end
    write_bit(!give_ack);
  endtask

  // write n bytes from idx, checking every acknowledge
  task automatic wr_seq(string req, logic [7:0] idx, logic [7:0] d0, logic [7:0] d1, int n);
    logic a;
    bus_start();
    write_byte(8'hD0, a); chk("R1 write address ack", {7'd0, a}, 8'd1);
    write_byte(idx, a);   chk({req, " index ack"}, {7'd0, a}, 8'd1);
    write_byte(d0, a);    chk({req, " data ack"}, {7'd0, a}, 8'd1);
    if (n > 1) begin
      write_byte(d1, a);  chk({req, " data ack"}, {7'd0, a}, 8'd1);
    end
    bus_stop();
  endtask

  task automatic rd_at(logic [7:0] idx, output logic [7:0] d);
    logic a, s;
    bus_start();
    write_byte(8'hD0, a);
    write_byte(idx, a);
    bus_start();
    write_byte(8'hD1, a);
    read_byte(1'b0, d, s);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R11 sda released after reset", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_addr_miss();
    logic a;
    bus_start();
    write_byte(8'hA0, a); chk("R1 foreign address not acked", {7'd0, a}, 8'd0);
    write_byte(8'hD0, a); chk("R1 ignored until START", {7'd0, a}, 8'd0);
    bus_stop();
  endtask

  task automatic t_seq();
    logic a, s;
    logic [7:0] d;
    logic a2;
    bus_start();
    write_byte(8'hD0, a);
    write_byte(8'h10, a); chk("R3 index ack", {7'd0, a}, 8'd1);
    write_byte(8'hA5, a); chk("R3 byte0 ack", {7'd0, a}, 8'd1);
    write_byte(8'h3C, a); chk("R3 byte1 ack", {7'd0, a}, 8'd1);
    write_byte(8'h00, a); chk("R3 byte2 ack", {7'd0, a}, 8'd1);
    bus_stop();
    bus_start();
    write_byte(8'hD0, a);
    write_byte(8'h10, a);
    bus_start();
    write_byte(8'hD1, a); chk("R2 repeated START read address ack", {7'd0, a}, 8'd1);
    read_byte(1'b1, d, s); chk("R4 read byte0", d, 8'hA5);
    chk("R7 sda steady while SCL high", {7'd0, s}, 8'd1);
    read_byte(1'b1, d, s); chk("R4 read byte1", d, 8'h3C);
    chk("R7 sda steady while SCL high", {7'd0, s}, 8'd1);
    read_byte(1'b0, d, s); chk("R4 read byte2", d, 8'h00);
    read_byte(1'b0, d, s); chk("R5 released after NACK", d, 8'hFF);
    bus_stop();
    for (int i = 7; i >= 0; i--) write_bit(i[0] ? 1'b0 : 1'b1);
    read_bit(a2, s);
    chk("R2 no ack after STOP", {7'd0, a2}, 8'd1);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    logic a, s;
    wr_seq("R6", 8'h9F, 8'h5A, 8'h6B, 2);
    rd_at(8'h00, d); chk("R6 write wrapped to 00h", d, 8'h6B);
    bus_start();
    write_byte(8'hD0, a);
    write_byte(8'h9F, a);
    bus_start();
    write_byte(8'hD1, a);
    read_byte(1'b1, d, s); chk("R6 read at 9Fh", d, 8'h5A);
    read_byte(1'b0, d, s); chk("R6 read wrapped to 00h", d, 8'h6B);
    bus_stop();
    wr_seq("R3", 8'hC0, 8'h77, 8'h00, 1);
    rd_at(8'h00, d); chk("R3 index above 9Fh loads 00h", d, 8'h77);
  endtask

  task automatic t_reset_ptr();
    logic [7:0] d;
    logic a, s;
    wr_seq("R11", 8'h00, 8'h31, 8'h32, 2);
    rst_n = 1'b0; tick(4);
    rst_n = 1'b1; tick(4);
    chk("R11 sda released after reset", {7'd0, sda_oe}, 8'd0);
    bus_start();
    write_byte(8'hD1, a);
    read_byte(1'b0, d, s); chk("R11 pointer 00h after reset", d, 8'h31);
    bus_stop();
  endtask

  task automatic t_pf_abort();
    logic [7:0] d;
    logic a, s, b;
    wr_seq("R8", 8'h00, 8'h5C, 8'h00, 1);
    wr_seq("R8", 8'h60, 8'h00, 8'h00, 1);
    bus_start();
    write_byte(8'hD0, a);
    write_byte(8'h60, a);
    bus_start();
    write_byte(8'hD1, a);
    for (int i = 0; i < 3; i++) read_bit(b, s);
    chk("R8 slave driving before fail", {7'd0, sda_oe}, 8'd1);
    pf = 1'b1; tick(8);
    chk("R8 sda released on fail", {7'd0, sda_oe}, 8'd0);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b1; tick(HP);
    pf = 1'b0; tick(10);
    bus_start();
    write_byte(8'hD1, a);
    read_byte(1'b0, d, s); chk("R8 pointer cleared by fail", d, 8'h5C);
    bus_stop();
  endtask

  task automatic t_pf_ignore();
    logic a;
    logic [7:0] d;
    tick(RECOVER + 50);
    wr_seq("R9", 8'h70, 8'h11, 8'h00, 1);
    pf = 1'b1; tick(10);
    bus_start();
    write_byte(8'hD0, a); chk("R9 no ack during fail", {7'd0, a}, 8'd0);
    write_byte(8'h70, a);
    write_byte(8'hEE, a);
    bus_stop();
    pf = 1'b0; tick(RECOVER + 50);
    rd_at(8'h70, d); chk("R9 no store during fail", d, 8'h11);
  endtask

  task automatic t_lockout();
    logic [7:0] d;
    wr_seq("R10", 8'h50, 8'h12, 8'h13, 2);
    pf = 1'b1; tick(10);
    pf = 1'b0; tick(10);
    wr_seq("R10 locked", 8'h50, 8'h99, 8'h98, 2);
    tick(RECOVER);
    rd_at(8'h50, d); chk("R10 locked write dropped", d, 8'h12);
    rd_at(8'h51, d); chk("R10 locked write dropped", d, 8'h13);
    wr_seq("R10 open", 8'h50, 8'h34, 8'h00, 1);
    rd_at(8'h50, d); chk("R10 write after recovery", d, 8'h34);
  endtask

  initial begin
    tick(5);
    t_reset();
    rst_n = 1'b1; tick(5);
    t_reset();
    t_addr_miss();
    t_seq();
    t_wrap();
    t_reset_ptr();
    t_pf_abort();
    t_pf_ignore();
    t_lockout();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule